// File: doc/BRIEF.md
# Serial NOR Sector Erase Sequencer

This block erases a contiguous range of sectors on an external serial NOR flash without processor involvement. It drives a byte-wide SPI master through a request/acknowledge handshake. For every sector it issues a write-enable transaction, then the erase opcode with the sector address, and then polls the flash status byte until the busy flag drops or a cycle budget runs out. In a second mode it reads the three identification bytes of the flash and assembles them into one word.

Before any byte goes to the flash, the request is validated. A bad range, a zero erase opcode or a protected sector anywhere in the range ends the request at once with an error code. Once erasing has started, the sequencer walks upward through the range and stops at the first sector that fails.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with `last < first`, or with `(last+1)*sect_size > dev_size`, finishes with `err`=1 and asserts `spi_sel` at no point. This check takes precedence over R2 and R3.
- R2: If the range is valid and `erase_op` is 0x00, the request finishes with `err`=3 and no SPI transaction.
- R3: If the range is valid, the opcode is non-zero and any bit of `prot_mask` between `first` and `last` inclusive is set, the request finishes with `err`=2 and no SPI transaction. Protect bits outside the range have no effect.
- R4: Each erase transaction is preceded by its own one-byte transaction 0x06. `spi_sel` is low for at least one cycle between any two transactions.
- R5: The erase transaction is `erase_op` followed by the address `index*sect_size`, most significant byte first. The address is 4 bytes when `dev_size` > 2^24, and otherwise 3 bytes (bits 23:0).
- R6: After an erase, the status is read with a two-byte transaction (0x05, then one dummy byte), where bit 0 of the second received byte is the busy flag. Reads repeat, separated by more than `poll_gap` idle cycles, until busy is 0. One more status read is issued than the number of reads that return busy.
- R7: If a status read returns busy once `poll_limit` or more cycles have passed since the erase transaction ended, the request finishes with `err`=4.
- R8: Sectors are erased in ascending order from `first` to `last`, and the sequence stops after the first failing sector, with no further erase issued.
- R9: With `id_mode` set, one transaction 0x9F plus three dummy bytes is made. The first received byte goes to `id[7:0]`, the second to `id[15:8]` and the third to `id[23:16]`. A value of 0xFFFFFF gives `err`=5; otherwise `err`=0.
- R10: `done` is a one-cycle pulse at the end of every request. `err` and `id` keep their values until the next start. After reset, `done`, `err`, `id` and `spi_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a request while idle |
| id_mode | input | 1 | 1: read identification, 0: erase range |
| first | input | SW | First sector index |
| last | input | SW | Last sector index |
| sect_size | input | AW | Sector size in bytes |
| dev_size | input | AW | Device size in bytes |
| erase_op | input | 8 | Erase opcode, 0x00 = unsupported |
| prot_mask | input | NSECT | One protect bit per sector |
| poll_gap | input | CW | Idle cycles between status reads |
| poll_limit | input | CW | Busy timeout in cycles |
| spi_sel | output | 1 | Flash select, high during a transaction |
| spi_req | output | 1 | Byte request to the SPI engine |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | One-cycle byte completion from the engine |
| spi_rx | input | 8 | Byte received, valid with `spi_ack` |
| done | output | 1 | Request finished (pulse) |
| err | output | 3 | 0 ok, 1 range, 2 protected, 3 unsupported, 4 timeout, 5 no device |
| id | output | 24 | Assembled identification bytes |

## Verification
The hardest case to reach is a timeout in the middle of a range. The flash has to stay busy past the cycle budget after the first erase, and the sequencer must then issue no further erase. The bench's flash model holds its busy flag for a configurable number of status reads. A directed run sets that count beyond reach with a short `poll_limit`, and then checks that exactly one erase address was logged. Random runs vary the byte latency of the engine and the poll spacing, so that transaction boundaries land on different cycles.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NSECT = 16,
  parameter int AW = 32,
  parameter int CW = 24,
  parameter logic [7:0] OP_WEN = 8'h06,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_RDID = 8'h9F,
  localparam int SW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             id_mode,
  input  logic [SW-1:0]    first,
  input  logic [SW-1:0]    last,
  input  logic [AW-1:0]    sect_size,
  input  logic [AW-1:0]    dev_size,
  input  logic [7:0]       erase_op,
  input  logic [NSECT-1:0] prot_mask,
  input  logic [CW-1:0]    poll_gap,
  input  logic [CW-1:0]    poll_limit,
  output logic             spi_sel,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx,
  output logic             done,
  output logic [2:0]       err,
  output logic [23:0]      id
);
  localparam int PW = AW + SW + 1;
  localparam logic [2:0] E_NONE = 3'd0, E_RANGE = 3'd1, E_PROT = 3'd2,
                         E_UNSUP = 3'd3, E_TMO = 3'd4, E_NODEV = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_WAIT} st_t;
  typedef enum logic [1:0] {K_WEN, K_ERASE, K_RDSR, K_ID} kind_t;

  st_t st;
  kind_t kind;
  logic [2:0] idx, nbytes, shk;
  logic [SW-1:0] cur, last_r;
  logic [7:0] op_r;
  logic addr4;
  logic [AW-1:0] ssz_r, sec_addr;
  logic [CW-1:0] gap_r, lim_r, wcnt, tcnt;
  logic stat_busy, wel_sent, done_r;
  logic [2:0] err_r;
  logic [23:0] id_r;
  logic [NSECT-1:0] in_rng;
  logic [PW-1:0] span_end;
  logic bad_range, prot_hit, last_byte;

  assign span_end  = (PW'(last) + PW'(1)) * PW'(sect_size);
  assign bad_range = (last < first) || (span_end > PW'(dev_size));
  always_comb
    for (int i = 0; i < NSECT; i++)
      in_rng[i] = (SW'(i) >= first) && (SW'(i) <= last);
  assign prot_hit = |(in_rng & prot_mask);

  assign sec_addr = ssz_r * AW'(cur);
  assign shk = (addr4 ? 3'd4 : 3'd3) - idx;
  always_comb begin
    case (kind)
      K_WEN:   nbytes = 3'd1;
      K_ERASE: nbytes = addr4 ? 3'd5 : 3'd4;
      K_RDSR:  nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    case (kind)
      K_WEN:   spi_tx = OP_WEN;
      K_ERASE: spi_tx = (idx == 3'd0) ? op_r : 8'(sec_addr >> {shk, 3'b000});
      K_RDSR:  spi_tx = (idx == 3'd0) ? OP_RDSR : 8'h00;
      default: spi_tx = (idx == 3'd0) ? OP_RDID : 8'h00;
    endcase
  end
  assign last_byte = (idx == nbytes - 3'd1);

  assign spi_sel = (st == S_XFER);
  assign spi_req = (st == S_XFER);
  assign done = done_r;
  assign err = err_r;
  assign id = id_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WEN; idx <= '0; cur <= '0; last_r <= '0;
      op_r <= '0; addr4 <= 1'b0; ssz_r <= '0; gap_r <= '0; lim_r <= '0;
      wcnt <= '0; tcnt <= '0; stat_busy <= 1'b0; wel_sent <= 1'b0;
      done_r <= 1'b0; err_r <= E_NONE; id_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (st != S_IDLE && tcnt != '1) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          err_r <= E_NONE;
          idx <= '0;
          if (id_mode) begin
            id_r <= '0; kind <= K_ID; st <= S_XFER;
          end else if (bad_range) begin
            err_r <= E_RANGE; done_r <= 1'b1;
          end else if (erase_op == 8'h00) begin
            err_r <= E_UNSUP; done_r <= 1'b1;
          end else if (prot_hit) begin
            err_r <= E_PROT; done_r <= 1'b1;
          end else begin
            cur <= first; last_r <= last; op_r <= erase_op;
            addr4 <= dev_size > AW'(32'h0100_0000);
            ssz_r <= sect_size; gap_r <= poll_gap; lim_r <= poll_limit;
            kind <= K_WEN; st <= S_XFER;
          end
        end
        S_XFER: if (spi_ack) begin
          if (kind == K_RDSR && idx == 3'd1) stat_busy <= spi_rx[0];
          if (kind == K_ID)
            case (idx)
              3'd1: id_r[7:0] <= spi_rx;
              3'd2: id_r[15:8] <= spi_rx;
              3'd3: id_r[23:16] <= spi_rx;
              default: ;
            endcase
          if (last_byte) begin
            st <= S_GAP;
            if (kind == K_WEN) wel_sent <= 1'b1;
            if (kind == K_ERASE) begin
              wel_sent <= 1'b0; tcnt <= '0;
            end
          end else idx <= idx + 1'b1;
        end
        S_GAP: begin
          idx <= '0;
          wcnt <= '0;
          case (kind)
            K_WEN: begin kind <= K_ERASE; st <= S_XFER; end
            K_ERASE: st <= S_WAIT;
            K_RDSR:
              if (!stat_busy) begin
                if (cur == last_r) begin
                  st <= S_IDLE; done_r <= 1'b1; err_r <= E_NONE;
                end else begin
                  cur <= cur + 1'b1; kind <= K_WEN; st <= S_XFER;
                end
              end else if (tcnt >= lim_r) begin
                st <= S_IDLE; done_r <= 1'b1; err_r <= E_TMO;
              end else st <= S_WAIT;
            default: begin
              st <= S_IDLE; done_r <= 1'b1;
              err_r <= (id_r == 24'hFF_FFFF) ? E_NODEV : E_NONE;
            end
          endcase
        end
        default: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt >= gap_r) begin kind <= K_RDSR; st <= S_XFER; end
        end
      endcase
    end
  end

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !id_mode && (bad_range || erase_op == 8'h00 || prot_hit))
      |=> (!spi_sel && done)); // R1
  AST_WEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && kind == K_ERASE) |-> wel_sent); // R4
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> cur >= $past(cur)); // R8
  AST_TIMEOUT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_TMO) |-> tcnt >= lim_r); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic clk = 0, rst_n = 0, start = 0, id_mode = 0;
  logic [3:0] first = 0, last = 0;
  logic [31:0] sect_size = 0, dev_size = 0;
  logic [7:0] erase_op = 0;
  logic [NS-1:0] prot_mask = 0;
  logic [23:0] poll_gap = 0, poll_limit = 0;
  logic spi_sel, spi_req, spi_ack = 0;
  logic [7:0] spi_tx, spi_rx = 0;
  logic done;
  logic [2:0] err;
  logic [23:0] id;

  flash_erase_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .id_mode(id_mode),
    .first(first), .last(last), .sect_size(sect_size), .dev_size(dev_size),
    .erase_op(erase_op), .prot_mask(prot_mask), .poll_gap(poll_gap),
    .poll_limit(poll_limit), .spi_sel(spi_sel), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_ack(spi_ack), .spi_rx(spi_rx), .done(done), .err(err), .id(id));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  // flash model state
  int lat = 0, pos = 0, n_erase = 0, n_xfer = 0, n_rdsr = 0, wen_viol = 0, last_len = 0;
  bit wel = 0;
  longint unsigned busy_left = 0, busy_polls = 0;
  logic [7:0] opc = 0;
  logic [63:0] abuf = 0;
  logic [23:0] id_val = 0;
  logic [31:0] log_addr [0:31];
  int log_len [0:31];

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finalize();
    n_xfer++;
    last_len = pos;
    case (opc)
      8'h06: if (pos == 1) wel = 1;
      8'h05: begin n_rdsr++; if (busy_left > 0) busy_left--; end
      8'h9F: ;
      default: begin
        if (!wel) wen_viol++;
        if (n_erase < 32) begin
          log_addr[n_erase] = abuf[31:0];
          log_len[n_erase] = pos - 1;
        end
        n_erase++;
        wel = 0;
        busy_left = busy_polls;
      end
    endcase
    pos = 0;
    abuf = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (spi_req) begin
        repeat (lat) @(negedge clk);
        if (pos == 0) opc = spi_tx;
        else abuf = {abuf[55:0], spi_tx};
        spi_rx = 8'h00;
        if (opc == 8'h9F && pos >= 1 && pos <= 3) spi_rx = 8'(id_val >> (8*(pos-1)));
        if (opc == 8'h05 && pos == 1) spi_rx = {7'b0, busy_left != 0};
        spi_ack = 1;
        pos++;
        @(negedge clk);
        spi_ack = 0;
        spi_rx = 0;
        if (!spi_sel) finalize();
      end else if (!spi_sel && pos != 0) finalize();
    end
  end

  function automatic logic [2:0] exp_err(int f, int l, longint unsigned ss, longint unsigned ds,
                                         logic [7:0] op, logic [NS-1:0] pm);
    if (l < f || longint'(l + 1) * ss > ds) return 3'd1;
    if (op == 8'h00) return 3'd3;
    for (int i = f; i <= l; i++) if (pm[i]) return 3'd2;
    return 3'd0;
  endfunction

  task automatic clear_model();
    pos = 0; n_erase = 0; n_xfer = 0; n_rdsr = 0; wen_viol = 0; wel = 0; busy_left = 0;
  endtask

  task automatic go_wait(output bit ok);
    int w;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    ok = done;
    if (!ok) chk("watchdog", 0, 1);
  endtask

  task automatic run_erase(int f, int l, longint unsigned ss, longint unsigned ds,
                           logic [7:0] op, logic [NS-1:0] pm, longint unsigned bp,
                           int gap, int lim, logic [2:0] force_exp, bit use_force);
    logic [2:0] e, e_held;
    bit ok;
    int nexp;
    logic [31:0] a;
    clear_model();
    busy_polls = bp;
    id_mode = 0; first = 4'(f); last = 4'(l); sect_size = 32'(ss); dev_size = 32'(ds);
    erase_op = op; prot_mask = pm; poll_gap = 24'(gap); poll_limit = 24'(lim);
    e = use_force ? force_exp : exp_err(f, l, ss, ds, op, pm);
    go_wait(ok);
    if (!ok) return;
    case (e)
      3'd1: chk("R1 err", err, e);
      3'd2: chk("R3 err", err, e);
      3'd3: chk("R2 err", err, e);
      3'd4: chk("R7 err", err, e);
      default: chk("R8 err", err, e);
    endcase
    e_held = err;
    if (e == 3'd1 || e == 3'd2 || e == 3'd3) chk("R1 R2 R3 no transaction", n_xfer, 0);
    if (e == 3'd4) begin
      chk("R8 stop after first failing sector", n_erase, 1);
      chk("R7 failing address", log_addr[0], 32'(longint'(f) * ss));
    end
    if (e == 3'd0) begin
      nexp = l - f + 1;
      chk("R8 erase count", n_erase, nexp);
      chk("R4 write enable before each erase", wen_viol, 0);
      chk("R6 status reads", n_rdsr, longint'(nexp) * (bp + 1));
      for (int i = 0; i < nexp && i < 32; i++) begin
        a = 32'(longint'(f + i) * ss);
        if (ds <= 64'h100_0000) a = a & 32'h00FF_FFFF;
        chk("R5 address", log_addr[i], a);
        chk("R5 address length", log_len[i], (ds > 64'h100_0000) ? 4 : 3);
      end
    end
    @(negedge clk);
    chk("R10 done is a pulse", done, 0);
    chk("R10 err held", err, e_held);
  endtask

  task automatic run_id(logic [23:0] v);
    bit ok;
    clear_model();
    id_val = v; id_mode = 1;
    go_wait(ok);
    id_mode = 0;
    if (!ok) return;
    chk("R9 id", id, v);
    chk("R9 err", err, (v == 24'hFF_FFFF) ? 3'd5 : 3'd0);
    chk("R9 one transaction", n_xfer, 1);
    chk("R9 transaction length", last_len, 4);
    @(negedge clk);
    chk("R10 id held", id, v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog global", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [0:4];
    longint unsigned szs [0:2];
    longint unsigned dvs [0:3];
    ops[0] = 8'h20; ops[1] = 8'hD8; ops[2] = 8'h52; ops[3] = 8'h21; ops[4] = 8'hDC;
    szs[0] = 4096; szs[1] = 65536; szs[2] = 1 << 20;
    dvs[0] = 1 << 20; dvs[1] = 1 << 24; dvs[2] = 1 << 25; dvs[3] = 1 << 26;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset done", done, 0);
    chk("R10 reset err", err, 0);
    chk("R10 reset id", id, 0);
    chk("R10 reset select", spi_sel, 0);
    rst_n = 1;
    @(negedge clk);

    // directed corners
    run_erase(0, 15, 1 << 20, 1 << 24, 8'hD8, 0, 1, 2, 100000, 0, 0);         // R5 3-byte edge
    run_erase(3, 15, 1 << 21, 1 << 25, 8'hDC, 0, 0, 0, 100000, 0, 0);         // R5 4-byte
    run_erase(0, 8, 1 << 17, 1 << 20, 8'h20, 0, 0, 0, 100000, 0, 0);          // R1 beyond size
    run_erase(9, 4, 4096, 1 << 20, 8'h20, 0, 0, 0, 100000, 0, 0);             // R1 reversed
    run_erase(9, 4, 4096, 1 << 20, 8'h00, 16'hFFFF, 0, 0, 100000, 0, 0);      // R1 precedence
    run_erase(2, 5, 4096, 1 << 20, 8'h00, 0, 0, 0, 100000, 0, 0);             // R2
    run_erase(2, 5, 4096, 1 << 20, 8'h20, 16'h0020, 0, 0, 100000, 0, 0);      // R3 last sector
    run_erase(2, 5, 4096, 1 << 20, 8'h20, 16'h8003, 2, 1, 100000, 0, 0);      // R3 outside range
    run_erase(2, 5, 65536, 1 << 24, 8'hD8, 0, 64'hFFFF_FFFF, 3, 300, 3'd4, 1); // R7 timeout
    run_erase(7, 7, 4096, 1 << 20, 8'h20, 0, 3, 4, 100000, 0, 0);             // R6 single sector
    run_id(24'h1840EF);
    run_id(24'hFFFFFF);
    run_id(24'h000001);

    // random mix
    for (int n = 0; n < 30; n++) begin
      int f, l;
      logic [NS-1:0] pm;
      f = int'($urandom % 16);
      l = int'($urandom % 16);
      pm = ($urandom % 2 == 0) ? '0 : NS'(1) << ($urandom % 16);
      lat = int'($urandom % 3);
      run_erase(f, l, szs[$urandom % 3], dvs[$urandom % 4],
                ($urandom % 10 == 0) ? 8'h00 : ops[$urandom % 5], pm,
                $urandom % 4, int'($urandom % 5), 100000, 0, 0);
    end
    lat = 1;
    run_id(24'(($urandom % 24'hFFFFFE)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule